// File: doc/BRIEF.md
# Execute-Stage Issue Gate and Branch Resolver

This block sits in the execute stage of an in-order pipeline and decides what happens to each instruction request offered in a cycle. Up to `SLOTS` requests arrive together. Each carries class flags (nop, control, serialize-after, syscall), an inbound fault flag, a thread id, a sequence number, the predicted and resolved branch direction, and the resolved next PC. The arithmetic datapath is not part of the block. Its only trace here is one fault bit per slot.

The slots are judged in ascending index order within a cycle, and each request gets one of three outcomes:

- **Completed:** executed, or passed through with its fault.
- **Refused:** the request must retry in a later cycle.
- **Idle:** the slot was not valid.

A serialize-after instruction that executes shuts out every later slot for the rest of that cycle. Only one control instruction may execute per cycle.

Resolved branches that disagree with their prediction raise a squash-and-redirect, and so do syscalls that execute cleanly. When several slots want a squash, the oldest one by sequence number wins. Saturating counters track executions, mispredicts split by predicted direction, total mispredicts and correct predictions.

Top module: `exec_gate`

## Requirements
- R1: A valid request with `req_fault` set completes as a pass-through whatever else is true in the cycle, including a serialize barrier or an earlier control instruction: `done_o`=1, `fault_o`=1, `exec_o`=0, `retry_o`=0. It changes no counter and raises no squash.
- R2: Once a slot without an inbound fault, not a nop, and not blocked has executed with `req_ser`=1, every later valid slot in the same cycle that has no inbound fault gets `retry_o`=1 and `done_o`=0. The barrier does not carry into the next cycle.
- R3: Only the first executing control request in a cycle runs. A later valid control request (no inbound fault, not a nop, not behind a barrier) gets `retry_o`=1.
- R4: A valid nop with no inbound fault and no barrier completes with `done_o`=1 and `exec_o`=1. It does not change `cnt_exec`.
- R5: Each control or ALU request that executes adds one to `cnt_exec` at the next clock edge. This includes requests whose `alu_fault` is set.
- R6: A control request that executes without `alu_fault` and whose `req_pred_tk` differs from `req_act_tk` raises `sq_valid` in the same cycle. `sq_tid`, `sq_seq` and `sq_pc` are that slot's `req_tid`, `req_seq` and `req_npc`.
- R7: An executing, fault-free control request updates the counters at the next edge as follows:
  - a mispredict adds one to `cnt_mispred`, and also to `cnt_tk_bad` if `req_pred_tk`=1 or to `cnt_nt_bad` if `req_pred_tk`=0;
  - a correct prediction adds one to `cnt_good`.
- R8: An executed request with `alu_fault`=1 completes with `done_o`=1, `fault_o`=1 and `exec_o`=0. It raises no squash and changes no prediction counter.
- R9: A non-control request with `req_sys`=1 that executes without `alu_fault` raises a squash carrying its own `req_tid`, `req_seq` and `req_npc`.
- R10: When more than one slot raises a squash in a cycle, the squash output carries the one with the smallest `req_seq`. On equal values the lower slot index wins.
- R11: All counters are `CNT_W` bits wide, stop at all-ones instead of wrapping, and read zero on the edge after a synchronous `rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | SLOTS | Slot holds a request |
| req_nop | input | SLOTS | Instruction is a nop |
| req_ctrl | input | SLOTS | Instruction is control flow |
| req_ser | input | SLOTS | Instruction is serialize-after |
| req_sys | input | SLOTS | Instruction is syscall class |
| req_fault | input | SLOTS | Instruction already carries a fault |
| req_tid | input | SLOTS*TID_W | Thread id per slot |
| req_seq | input | SLOTS*SEQ_W | Sequence number per slot |
| req_pred_tk | input | SLOTS | Predicted taken |
| req_act_tk | input | SLOTS | Resolved taken |
| req_npc | input | SLOTS*PC_W | Resolved next PC |
| alu_fault | input | SLOTS | Datapath raised a fault on execution |
| done_o | output | SLOTS | Request completed |
| retry_o | output | SLOTS | Request refused, must retry |
| exec_o | output | SLOTS | Instruction marked executed |
| fault_o | output | SLOTS | Fault travels to the next stage |
| sq_valid | output | 1 | Squash-and-redirect request |
| sq_tid | output | TID_W | Thread of the squash |
| sq_seq | output | SEQ_W | Sequence number of the squashing instruction |
| sq_pc | output | PC_W | Redirect target |
| cnt_exec | output | CNT_W | Executions |
| cnt_tk_bad | output | CNT_W | Mispredicts that were predicted taken |
| cnt_nt_bad | output | CNT_W | Mispredicts that were predicted not taken |
| cnt_mispred | output | CNT_W | All mispredicts |
| cnt_good | output | CNT_W | Correct predictions |

## Verification
A branch mispredict and a syscall squash can both ask for a redirect in the same cycle. Only one of them may reach the squash port.

The bench provokes this case in two ways:
- a directed cycle places a mispredicting branch in a low slot and a syscall with a smaller sequence number in a higher slot;
- random cycles with unordered sequence numbers add further collisions.

A behavioural model picks the oldest candidate by scanning the slots, and the squash port is compared against it every cycle. The same comparison covers a serialize barrier and a second control request landing in one cycle, where slot order decides which rule refuses the later slot.

// File: rtl/exec_gate.sv
module exec_gate #(
  parameter int SLOTS = 3,
  parameter int TID_W = 2,
  parameter int SEQ_W = 16,
  parameter int PC_W  = 32,
  parameter int CNT_W = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [SLOTS-1:0]         req_valid,
  input  logic [SLOTS-1:0]         req_nop,
  input  logic [SLOTS-1:0]         req_ctrl,
  input  logic [SLOTS-1:0]         req_ser,
  input  logic [SLOTS-1:0]         req_sys,
  input  logic [SLOTS-1:0]         req_fault,
  input  logic [SLOTS*TID_W-1:0]   req_tid,
  input  logic [SLOTS*SEQ_W-1:0]   req_seq,
  input  logic [SLOTS-1:0]         req_pred_tk,
  input  logic [SLOTS-1:0]         req_act_tk,
  input  logic [SLOTS*PC_W-1:0]    req_npc,
  input  logic [SLOTS-1:0]         alu_fault,
  output logic [SLOTS-1:0]         done_o,
  output logic [SLOTS-1:0]         retry_o,
  output logic [SLOTS-1:0]         exec_o,
  output logic [SLOTS-1:0]         fault_o,
  output logic                     sq_valid,
  output logic [TID_W-1:0]         sq_tid,
  output logic [SEQ_W-1:0]         sq_seq,
  output logic [PC_W-1:0]          sq_pc,
  output logic [CNT_W-1:0]         cnt_exec,
  output logic [CNT_W-1:0]         cnt_tk_bad,
  output logic [CNT_W-1:0]         cnt_nt_bad,
  output logic [CNT_W-1:0]         cnt_mispred,
  output logic [CNT_W-1:0]         cnt_good
);

  localparam int IW = $clog2(SLOTS + 1);

  logic [IW-1:0] inc_exec, inc_tk, inc_nt, inc_good;

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a,
                                               input logic [IW-1:0] b);
    logic [CNT_W:0] s;
    s = {1'b0, a} + {{(CNT_W + 1 - IW){1'b0}}, b};
    return s[CNT_W] ? {CNT_W{1'b1}} : s[CNT_W-1:0];
  endfunction

  always_comb begin
    logic bar, cseen, want;
    bar = 1'b0;
    cseen = 1'b0;
    done_o = '0;
    retry_o = '0;
    exec_o = '0;
    fault_o = '0;
    sq_valid = 1'b0;
    sq_tid = '0;
    sq_seq = '0;
    sq_pc = '0;
    inc_exec = '0;
    inc_tk = '0;
    inc_nt = '0;
    inc_good = '0;
    for (int i = 0; i < SLOTS; i++) begin
      want = 1'b0;
      if (req_valid[i]) begin
        if (req_fault[i]) begin
          done_o[i] = 1'b1;
          fault_o[i] = 1'b1;
        end else if (bar) begin
          retry_o[i] = 1'b1;
        end else if (req_nop[i]) begin
          done_o[i] = 1'b1;
          exec_o[i] = 1'b1;
        end else if (req_ctrl[i] && cseen) begin
          retry_o[i] = 1'b1;
        end else begin
          done_o[i] = 1'b1;
          inc_exec = inc_exec + IW'(1);
          if (req_ser[i]) bar = 1'b1;
          if (req_ctrl[i]) cseen = 1'b1;
          if (alu_fault[i]) begin
            fault_o[i] = 1'b1;
          end else begin
            exec_o[i] = 1'b1;
            if (req_ctrl[i]) begin
              if (req_pred_tk[i] != req_act_tk[i]) begin
                want = 1'b1;
                if (req_pred_tk[i]) inc_tk = inc_tk + IW'(1);
                else inc_nt = inc_nt + IW'(1);
              end else begin
                inc_good = inc_good + IW'(1);
              end
            end else if (req_sys[i]) begin
              want = 1'b1;
            end
          end
        end
      end
      if (want && (!sq_valid || req_seq[i*SEQ_W +: SEQ_W] < sq_seq)) begin
        sq_valid = 1'b1;
        sq_tid = req_tid[i*TID_W +: TID_W];
        sq_seq = req_seq[i*SEQ_W +: SEQ_W];
        sq_pc = req_npc[i*PC_W +: PC_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_exec <= '0;
      cnt_tk_bad <= '0;
      cnt_nt_bad <= '0;
      cnt_mispred <= '0;
      cnt_good <= '0;
    end else begin
      cnt_exec <= sat_add(cnt_exec, inc_exec);
      cnt_tk_bad <= sat_add(cnt_tk_bad, inc_tk);
      cnt_nt_bad <= sat_add(cnt_nt_bad, inc_nt);
      cnt_mispred <= sat_add(cnt_mispred, IW'(inc_tk + inc_nt));
      cnt_good <= sat_add(cnt_good, inc_good);
    end
  end

  logic [SLOTS-1:0] ran_ser_before, ran_ctrl_before, ctrl_ran;

  always_comb begin
    ran_ser_before = '0;
    ran_ctrl_before = '0;
    for (int i = 0; i < SLOTS; i++) begin
      ctrl_ran[i] = req_valid[i] & done_o[i] & ~req_fault[i] & ~req_nop[i] & req_ctrl[i];
      for (int j = 0; j < i; j++) begin
        if (req_valid[j] && done_o[j] && !req_fault[j] && !req_nop[j] && req_ser[j])
          ran_ser_before[i] = 1'b1;
        if (ctrl_ran[j]) ran_ctrl_before[i] = 1'b1;
      end
    end
  end

  assert_one_ctrl_R3: assert property (@(posedge clk) disable iff (rst)
    $countones(ctrl_ran) <= 1);

  assert_squash_has_source_R6: assert property (@(posedge clk) disable iff (rst)
    sq_valid |-> |(done_o & exec_o & ~req_nop));

  assert_exec_monotonic_R11: assert property (@(posedge clk) disable iff (rst)
    !rst |=> cnt_exec >= $past(cnt_exec));

  assert_mispred_monotonic_R7: assert property (@(posedge clk) disable iff (rst)
    !rst |=> cnt_mispred >= $past(cnt_mispred));

  assert_reset_clears_R11: assert property (@(posedge clk)
    rst |=> (cnt_exec == '0) && (cnt_good == '0) && (cnt_mispred == '0));

  for (genvar g = 0; g < SLOTS; g++) begin : g_chk
    assert_fault_pass_R1: assert property (@(posedge clk) disable iff (rst)
      req_valid[g] && req_fault[g] |-> done_o[g] && fault_o[g] && !exec_o[g] && !retry_o[g]);

    assert_barrier_R2: assert property (@(posedge clk) disable iff (rst)
      req_valid[g] && !req_fault[g] && ran_ser_before[g] |-> retry_o[g] && !done_o[g]);

    assert_ctrl_block_R3: assert property (@(posedge clk) disable iff (rst)
      req_valid[g] && !req_fault[g] && !ran_ser_before[g] && !req_nop[g] &&
      req_ctrl[g] && ran_ctrl_before[g] |-> retry_o[g]);

    assert_done_xor_retry_R2: assert property (@(posedge clk) disable iff (rst)
      !(done_o[g] && retry_o[g]));
  end

endmodule

// File: tb/exec_gate_tb.sv
module exec_gate_tb;
  localparam int CLK_PERIOD = 10;
  localparam int S = 3;
  localparam int TW = 2;
  localparam int QW = 8;
  localparam int PW = 16;
  localparam int CW = 6;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 0, rst = 1;
  logic [S-1:0] v, nop, ctl, ser, sys, flt, ptk, atk, af;
  logic [S*TW-1:0] tid;
  logic [S*QW-1:0] seq;
  logic [S*PW-1:0] npc;
  logic [S-1:0] done_o, retry_o, exec_o, fault_o;
  logic sq_valid;
  logic [TW-1:0] sq_tid;
  logic [QW-1:0] sq_seq;
  logic [PW-1:0] sq_pc;
  logic [CW-1:0] c_ex, c_tk, c_nt, c_mp, c_gd;

  int checks = 0, errors = 0;
  int m_ex, m_tk, m_nt, m_mp, m_gd;
  int i_ex, i_tk, i_nt, i_gd;

  always #(CLK_PERIOD/2) clk = ~clk;

  exec_gate #(.SLOTS(S), .TID_W(TW), .SEQ_W(QW), .PC_W(PW), .CNT_W(CW)) u_dut (
    .clk(clk), .rst(rst), .req_valid(v), .req_nop(nop), .req_ctrl(ctl),
    .req_ser(ser), .req_sys(sys), .req_fault(flt), .req_tid(tid), .req_seq(seq),
    .req_pred_tk(ptk), .req_act_tk(atk), .req_npc(npc), .alu_fault(af),
    .done_o(done_o), .retry_o(retry_o), .exec_o(exec_o), .fault_o(fault_o),
    .sq_valid(sq_valid), .sq_tid(sq_tid), .sq_seq(sq_seq), .sq_pc(sq_pc),
    .cnt_exec(c_ex), .cnt_tk_bad(c_tk), .cnt_nt_bad(c_nt), .cnt_mispred(c_mp),
    .cnt_good(c_gd));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear();
    v = '0; nop = '0; ctl = '0; ser = '0; sys = '0; flt = '0;
    ptk = '0; atk = '0; af = '0; tid = '0; seq = '0; npc = '0;
  endtask

  task automatic put(int i, bit n, bit c, bit se, bit sy, bit f, int t, int q,
                     bit p, bit a, int pc, bit x);
    v[i] = 1; nop[i] = n; ctl[i] = c; ser[i] = se; sys[i] = sy; flt[i] = f;
    tid[i*TW +: TW] = TW'(t); seq[i*QW +: QW] = QW'(q);
    ptk[i] = p; atk[i] = a; npc[i*PW +: PW] = PW'(pc); af[i] = x;
  endtask

  task automatic model_and_compare();
    bit bar = 0, cs = 0, found = 0, multi = 0, fsys = 0;
    int bq = 0, bt = 0, bp = 0;
    string tag;
    i_ex = 0; i_tk = 0; i_nt = 0; i_gd = 0;
    for (int i = 0; i < S; i++) begin
      int ed = 0, er = 0, ee = 0, ef = 0;
      bit want = 0;
      tag = "R5";
      if (v[i]) begin
        if (flt[i]) begin ed = 1; ef = 1; tag = "R1"; end
        else if (bar) begin er = 1; tag = "R2"; end
        else if (nop[i]) begin ed = 1; ee = 1; tag = "R4"; end
        else if (ctl[i] && cs) begin er = 1; tag = "R3"; end
        else begin
          ed = 1; i_ex++;
          if (ser[i]) bar = 1;
          if (ctl[i]) cs = 1;
          if (af[i]) begin ef = 1; tag = "R8"; end
          else begin
            ee = 1;
            if (ctl[i]) begin
              if (ptk[i] != atk[i]) begin
                want = 1;
                if (ptk[i]) i_tk++; else i_nt++;
              end else i_gd++;
            end else if (sys[i]) want = 1;
          end
        end
      end
      if (want) begin
        if (found) multi = 1;
        if (!found || int'(seq[i*QW +: QW]) < bq) begin
          found = 1; bq = int'(seq[i*QW +: QW]);
          bt = int'(tid[i*TW +: TW]); bp = int'(npc[i*PW +: PW]);
          fsys = !ctl[i];
        end
      end
      chk({tag, " done"}, int'(done_o[i]), ed);
      chk({tag, " retry"}, int'(retry_o[i]), er);
      chk({tag, " exec"}, int'(exec_o[i]), ee);
      chk({tag, " fault"}, int'(fault_o[i]), ef);
    end
    tag = multi ? "R10" : (fsys ? "R9" : "R6");
    chk({tag, " sq_valid"}, int'(sq_valid), int'(found));
    if (found) begin
      chk({tag, " sq_tid"}, int'(sq_tid), bt);
      chk({tag, " sq_seq"}, int'(sq_seq), bq);
      chk({tag, " sq_pc"}, int'(sq_pc), bp);
    end
  endtask

  function automatic int sat(int a, int b);
    return (a + b > CMAX) ? CMAX : a + b;
  endfunction

  task automatic step();
    #1;
    if (!rst) model_and_compare();
    else begin i_ex = 0; i_tk = 0; i_nt = 0; i_gd = 0; end
    @(posedge clk);
    if (rst) begin m_ex = 0; m_tk = 0; m_nt = 0; m_mp = 0; m_gd = 0; end
    else begin
      m_ex = sat(m_ex, i_ex); m_tk = sat(m_tk, i_tk); m_nt = sat(m_nt, i_nt);
      m_mp = sat(m_mp, i_tk + i_nt); m_gd = sat(m_gd, i_gd);
    end
    @(negedge clk);
    chk((m_ex == CMAX) ? "R11 cnt_exec" : "R5 cnt_exec", int'(c_ex), m_ex);
    chk("R7 cnt_tk_bad", int'(c_tk), m_tk);
    chk("R7 cnt_nt_bad", int'(c_nt), m_nt);
    chk("R7 cnt_mispred", int'(c_mp), m_mp);
    chk("R7 cnt_good", int'(c_gd), m_gd);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clear();
    @(negedge clk);
    step(); step();
    chk("R11 reset cnt_exec", int'(c_ex), 0);
    chk("R11 reset cnt_good", int'(c_gd), 0);
    rst = 0;
    // R2 barrier, R1 fault passes the barrier
    clear();
    put(0, 0, 0, 1, 0, 0, 1, 10, 0, 0, 16'h100, 0);
    put(1, 0, 0, 0, 0, 1, 1, 11, 0, 0, 16'h104, 0);
    put(2, 0, 0, 0, 0, 0, 1, 12, 0, 0, 16'h108, 0);
    step();
    // R2 barrier cleared next cycle
    clear();
    put(0, 0, 0, 0, 0, 0, 0, 13, 0, 0, 0, 0);
    put(1, 0, 0, 0, 0, 0, 0, 14, 0, 0, 0, 0);
    step();
    // R3 second control blocked, R4 nop
    clear();
    put(0, 0, 1, 0, 0, 0, 2, 20, 1, 1, 16'h200, 0);
    put(1, 0, 1, 0, 0, 0, 2, 21, 0, 1, 16'h204, 0);
    put(2, 1, 0, 0, 0, 0, 2, 22, 0, 0, 0, 0);
    step();
    // R6 + R9 + R10: branch mispredict and older syscall
    clear();
    put(0, 0, 1, 0, 0, 0, 3, 40, 1, 0, 16'h300, 0);
    put(1, 0, 0, 0, 1, 0, 1, 35, 0, 0, 16'h340, 0);
    step();
    // R8 exec fault on a mispredicting branch
    clear();
    put(0, 0, 1, 0, 0, 0, 0, 50, 0, 1, 16'h400, 1);
    step();
    // R7 not-taken mispredict
    clear();
    put(2, 0, 1, 0, 0, 0, 2, 60, 0, 1, 16'h480, 0);
    step();
    // random traffic, drives counters into saturation (R11)
    for (int n = 0; n < 900; n++) begin
      clear();
      for (int i = 0; i < S; i++) begin
        if ($urandom_range(0, 9) < 8) begin
          int k = $urandom_range(0, 9);
          put(i, k == 0, k >= 5, $urandom_range(0, 7) == 0, k == 1 || k == 2,
              $urandom_range(0, 9) == 0, $urandom_range(0, 3),
              $urandom_range(0, 255), $urandom_range(0, 1), $urandom_range(0, 1),
              $urandom_range(0, 65535), $urandom_range(0, 9) == 0);
        end
      end
      if (n == 450) rst = 1;
      if (n == 452) rst = 0;
      step();
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule